// File: doc/BRIEF.md
# Lowest-Occupancy Two-Thread Fetch Chooser

This block decides, every cycle, which two hardware threads of a simultaneous multithreaded front end may fetch. For each thread it keeps an occupancy count: the number of that thread's instructions that have been fetched but have not yet left the pre-execution region (decode, rename, instruction queue). Threads holding the fewest such instructions are the ones draining fastest, so giving them fetch slots keeps the queues full of work that can actually issue.

Per cycle the fetch unit reports how many instructions it delivered for each thread. The issue and squash logic reports how many left. Both amounts are applied to the counts at the same clock edge. A per-thread eligibility mask removes threads that must not fetch, for example stalled or idle ones. The two slot outputs are a combinational function of the registered counts and the current mask. Each slot carries a thread ID and a valid bit.

Top module: `occ_fetch_pick`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every occupancy count is cleared to zero and `underflow_err_o` is cleared.
- R2: At each rising edge, every thread's count becomes its old value plus its fetch amount minus its drain amount, both applied in the same edge. Amounts are 0 to 4, and thread i uses bits [3i+2:3i] of `fetch_add_i` and of `drain_sub_i`.
- R3: A count whose result would exceed 2^CNT_W-1 (63 by default) holds at 63 instead of wrapping.
- R4: A count whose result would go below zero is held at zero, and `underflow_err_o` goes high at that edge. It stays high until reset.
- R5: Slot 0 names the eligible thread (bit i of `fetch_ok_i` set) with the smallest count. Equal counts go to the lower thread ID.
- R6: Slot 1 names the eligible thread with the smallest count once the slot 0 thread is excluded. Equal counts go to the lower thread ID.
- R7: With exactly one eligible thread, only slot 0 is valid. With none, neither slot is valid. An invalid slot drives thread ID 0.
- R8: When both slots are valid, their thread IDs differ.
- R9: The slots follow a change of `fetch_ok_i` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_add_i | input | NUM_THR*DELTA_W | Per-thread count of instructions fetched this cycle |
| drain_sub_i | input | NUM_THR*DELTA_W | Per-thread count of instructions issued or squashed this cycle |
| fetch_ok_i | input | NUM_THR | Per-thread fetch eligibility |
| slot0_vld_o | output | 1 | Slot 0 holds a thread |
| slot0_tid_o | output | $clog2(NUM_THR) | Slot 0 thread ID |
| slot1_vld_o | output | 1 | Slot 1 holds a thread |
| slot1_tid_o | output | $clog2(NUM_THR) | Slot 1 thread ID |
| underflow_err_o | output | 1 | Sticky flag: some count was asked to go below zero |

## Verification
The bench drives a count past 63 and then compares it against a neighbour held at 62. A counter that wraps would jump to the front of the order, and one stuck at the limit would not move back after a drain. It also pairs a fetch and a drain on the same thread in one cycle, which catches a design that applies only one of them. An underflow in the same cycle as another thread's fetch must leave the first thread at zero, ahead of the other thread; a wrapping count would put it last. The flag must then survive idle cycles. Tie cases with all counts equal, or with many counts equal, expose a picker that prefers higher IDs. A picker that fails to exclude the first choice would repeat that ID in slot 1. Masks with one eligible thread, and with none, show whether slot 1 is validated when it should not be.

// File: rtl/ofp_pkg.sv
// Package ofp_pkg
// Shared defaults and the outcome type for the per-thread occupancy update.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ofp_pkg;
    localparam int DEF_NUM_THR = 8;
    localparam int DEF_CNT_W   = 6;
    localparam int DEF_DELTA_W = 3;

    typedef enum logic [1:0] {
        UPD_NORMAL = 2'd0,
        UPD_SAT    = 2'd1,
        UPD_UNDER  = 2'd2
    } upd_kind_e;
endpackage

// File: rtl/ofp_thread_ctr.sv
// Module ofp_thread_ctr
// One thread's occupancy counter. Fetch and drain amounts land in the same edge.
// The result saturates at the top of the range, and a result below zero clamps
// to zero with a one-cycle underflow indication.
// Assumes the amounts are unsigned and DELTA_W bits wide.
module ofp_thread_ctr
    import ofp_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int DELTA_W = DEF_DELTA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DELTA_W-1:0] add_i,
    input  logic [DELTA_W-1:0] sub_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               under_o
);
    localparam int SUM_W = ((CNT_W > DELTA_W) ? CNT_W : DELTA_W) + 2;
    localparam logic signed [SUM_W-1:0] TOP_S = SUM_W'((1 << CNT_W) - 1);

    logic [CNT_W-1:0]        cnt_q;
    logic signed [SUM_W-1:0] sum;
    upd_kind_e               kind;
    logic [CNT_W-1:0]        cnt_d;

    // Purpose: form the signed result of adding and removing in one step.
    always_comb begin
        sum = $signed({{(SUM_W-CNT_W){1'b0}}, cnt_q})
            + $signed({{(SUM_W-DELTA_W){1'b0}}, add_i})
            - $signed({{(SUM_W-DELTA_W){1'b0}}, sub_i});
    end

    // Purpose: classify the result and clamp it into range.
    always_comb begin
        if (sum < 0) begin
            kind = UPD_UNDER;
        end else if (sum > TOP_S) begin
            kind = UPD_SAT;
        end else begin
            kind = UPD_NORMAL;
        end
        case (kind)
            UPD_UNDER: cnt_d = '0;
            UPD_SAT:   cnt_d = {CNT_W{1'b1}};
            default:   cnt_d = sum[CNT_W-1:0];
        endcase
    end

    // Purpose: hold the occupancy count, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o   = cnt_q;
    assign under_o = (kind == UPD_UNDER);
endmodule

// File: rtl/ofp_min_pick.sv
// Module ofp_min_pick
// Purely combinational: among the threads whose mask bit is set, find the one
// with the smallest count. On equal counts the lowest index wins.
// Assumes counts are packed with thread i at [i*CNT_W +: CNT_W].
module ofp_min_pick #(
    parameter int NUM_THR = 8,
    parameter int CNT_W   = 6,
    parameter int TID_W   = $clog2(NUM_THR)
) (
    input  logic [NUM_THR*CNT_W-1:0] cnt_flat_i,
    input  logic [NUM_THR-1:0]       mask_i,
    output logic                     vld_o,
    output logic [TID_W-1:0]         id_o
);
    logic [CNT_W-1:0] best;

    // Purpose: ascending scan that replaces the best only on a strictly smaller count.
    always_comb begin
        vld_o = 1'b0;
        id_o  = '0;
        best  = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (mask_i[i] && (!vld_o || (cnt_flat_i[i*CNT_W +: CNT_W] < best))) begin
                vld_o = 1'b1;
                id_o  = TID_W'(i);
                best  = cnt_flat_i[i*CNT_W +: CNT_W];
            end
        end
    end
endmodule

// File: rtl/occ_fetch_pick.sv
// Module occ_fetch_pick
// Two-slot fetch-thread chooser driven by per-thread pre-execution occupancy.
// Slot 0 is the least-occupied eligible thread. Slot 1 is the least-occupied of
// the remaining eligible threads. Ties go to the lower thread ID.
// Assumes NUM_THR >= 2 and per-cycle amounts no larger than 2^DELTA_W-1.
module occ_fetch_pick
    import ofp_pkg::*;
#(
    parameter int NUM_THR = DEF_NUM_THR,
    parameter int CNT_W   = DEF_CNT_W,
    parameter int DELTA_W = DEF_DELTA_W,
    localparam int TID_W  = $clog2(NUM_THR)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_THR*DELTA_W-1:0] fetch_add_i,
    input  logic [NUM_THR*DELTA_W-1:0] drain_sub_i,
    input  logic [NUM_THR-1:0]         fetch_ok_i,
    output logic                       slot0_vld_o,
    output logic [TID_W-1:0]           slot0_tid_o,
    output logic                       slot1_vld_o,
    output logic [TID_W-1:0]           slot1_tid_o,
    output logic                       underflow_err_o
);
    logic [NUM_THR*CNT_W-1:0] cnt_flat;
    logic [NUM_THR-1:0]       under_vec;
    logic [NUM_THR-1:0]       rest_mask;
    logic                     err_q;

    // One occupancy counter per hardware thread.
    for (genvar t = 0; t < NUM_THR; t++) begin : g_ctr
        ofp_thread_ctr #(
            .CNT_W   (CNT_W),
            .DELTA_W (DELTA_W)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_i   (fetch_add_i[t*DELTA_W +: DELTA_W]),
            .sub_i   (drain_sub_i[t*DELTA_W +: DELTA_W]),
            .cnt_o   (cnt_flat[t*CNT_W +: CNT_W]),
            .under_o (under_vec[t])
        );
    end

    ofp_min_pick #(
        .NUM_THR    (NUM_THR),
        .CNT_W      (CNT_W),
        .TID_W      (TID_W)
    ) u_pick0 (
        .cnt_flat_i (cnt_flat),
        .mask_i     (fetch_ok_i),
        .vld_o      (slot0_vld_o),
        .id_o       (slot0_tid_o)
    );

    // Purpose: drop the slot 0 winner from the candidates for slot 1.
    always_comb begin
        rest_mask = fetch_ok_i;
        if (slot0_vld_o) begin
            rest_mask[slot0_tid_o] = 1'b0;
        end
    end

    ofp_min_pick #(
        .NUM_THR    (NUM_THR),
        .CNT_W      (CNT_W),
        .TID_W      (TID_W)
    ) u_pick1 (
        .cnt_flat_i (cnt_flat),
        .mask_i     (rest_mask),
        .vld_o      (slot1_vld_o),
        .id_o       (slot1_tid_o)
    );

    // Purpose: sticky underflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_q | (|under_vec);
        end
    end

    assign underflow_err_o = err_q;
endmodule

// File: rtl/occ_fetch_pick_chk.sv
// Module occ_fetch_pick_chk
// Port-level properties of the chooser, attached by bind.
// Assumes it sees the same clock and reset as the chooser.
module occ_fetch_pick_chk #(
    parameter int NUM_THR = 8,
    parameter int TID_W   = $clog2(NUM_THR)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_THR-1:0] fetch_ok_i,
    input logic               slot0_vld_o,
    input logic [TID_W-1:0]   slot0_tid_o,
    input logic               slot1_vld_o,
    input logic [TID_W-1:0]   slot1_tid_o,
    input logic               underflow_err_o
);
    // R8: the two valid slots never name the same thread.
    a_r8_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (slot0_vld_o && slot1_vld_o) |-> (slot0_tid_o != slot1_tid_o));

    // R7: slot 1 is never filled ahead of slot 0.
    a_r7_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_vld_o |-> slot0_vld_o);

    // R7: an empty mask leaves both slots empty.
    a_r7_none: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ok_i == '0) |-> (!slot0_vld_o && !slot1_vld_o));

    // R7: a single eligible thread fills only slot 0.
    a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fetch_ok_i) == 1) |-> (slot0_vld_o && !slot1_vld_o));

    // R5: slot 0 only names eligible threads.
    a_r5_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        slot0_vld_o |-> fetch_ok_i[slot0_tid_o]);

    // R6: slot 1 only names eligible threads.
    a_r6_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_vld_o |-> fetch_ok_i[slot1_tid_o]);

    // R6: two or more eligible threads fill both slots.
    a_r6_both: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fetch_ok_i) > 1) |-> (slot0_vld_o && slot1_vld_o));

    // R4: once raised, the underflow flag stays high until reset.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err_o |=> underflow_err_o);
endmodule

bind occ_fetch_pick occ_fetch_pick_chk #(
    .NUM_THR (NUM_THR)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_ok_i      (fetch_ok_i),
    .slot0_vld_o     (slot0_vld_o),
    .slot0_tid_o     (slot0_tid_o),
    .slot1_vld_o     (slot1_vld_o),
    .slot1_tid_o     (slot1_tid_o),
    .underflow_err_o (underflow_err_o)
);

// File: tb/occ_fetch_pick_bench.sv
module occ_fetch_pick_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] fetch_add = '0;
    logic [23:0] drain_sub = '0;
    logic [7:0]  fetch_ok = '0;
    logic        s0_vld, s1_vld, uerr;
    logic [2:0]  s0_tid, s1_tid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    occ_fetch_pick u_occ_fetch_pick (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_add_i     (fetch_add),
        .drain_sub_i     (drain_sub),
        .fetch_ok_i      (fetch_ok),
        .slot0_vld_o     (s0_vld),
        .slot0_tid_o     (s0_tid),
        .slot1_vld_o     (s1_vld),
        .slot1_tid_o     (s1_tid),
        .underflow_err_o (uerr)
    );

    // Table entry: {fetch hex digits, drain hex digits, mask, v0, id0, v1, id1}.
    // Hex digit i carries thread i's amount. Counts start at zero after reset.
    localparam int NV = 9;
    localparam logic [79:0] TBL [NV] = '{
        {32'h00000000, 32'h00000000, 8'hFF, 1'b1, 3'd0, 1'b1, 3'd1}, // all zero, ties -> 0,1
        {32'h00000034, 32'h00000000, 8'hFF, 1'b1, 3'd2, 1'b1, 3'd3}, // t0=4 t1=3
        {32'h00004400, 32'h00000000, 8'hFF, 1'b1, 3'd4, 1'b1, 3'd5}, // t2,t3=4
        {32'h44440000, 32'h00000000, 8'hFF, 1'b1, 3'd1, 1'b1, 3'd0}, // t1=3 lowest, 0 wins tie of 4s
        {32'h00000001, 32'h00000003, 8'hFF, 1'b1, 3'd0, 1'b1, 3'd1}, // t0: 4+1-3=2
        {32'h00000000, 32'h00000000, 8'hF0, 1'b1, 3'd4, 1'b1, 3'd5}, // upper half only
        {32'h00000000, 32'h00000000, 8'h80, 1'b1, 3'd7, 1'b0, 3'd0}, // single eligible
        {32'h00000000, 32'h00000000, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0}, // none eligible
        {32'h00000000, 32'h40000000, 8'hC0, 1'b1, 3'd7, 1'b1, 3'd6}  // t7 drains to 0
    };

    function automatic logic [23:0] unpack_hex(input logic [31:0] h);
        logic [23:0] r;
        for (int i = 0; i < 8; i++) r[3*i +: 3] = h[4*i +: 3];
        return r;
    endfunction

    task automatic check_slots(input string req, input logic [7:0] exp);
        logic [7:0] act;
        act = {s0_vld, s0_tid, s1_vld, s1_tid};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s slots v0/id0/v1/id1 actual %b/%0d/%b/%0d expected %b/%0d/%b/%0d",
                     req, act[7], act[6:4], act[3], act[2:0], exp[7], exp[6:4], exp[3], exp[2:0]);
        end
    endtask

    task automatic check_err(input string req, input logic exp);
        n_cmp++;
        if (uerr !== exp) begin
            n_bad++;
            $display("FAIL %s underflow flag actual %b expected %b", req, uerr, exp);
        end
    endtask

    // Drive one cycle of amounts, let the edge take them, sample 1 ns later.
    task automatic step(input logic [31:0] fh, input logic [31:0] dh, input logic [7:0] m);
        @(negedge clk);
        fetch_add = unpack_hex(fh);
        drain_sub = unpack_hex(dh);
        fetch_ok  = m;
        @(posedge clk);
        #1;
        fetch_add = '0;
        drain_sub = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fetch_add = '0;
        drain_sub = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        fetch_ok = 8'hFF;
        #1;
        // R1: reset state, all counts zero so the lowest IDs win, no error
        check_slots("R1", {1'b1, 3'd0, 1'b1, 3'd1});
        check_err("R1", 1'b0);

        // R2 R5 R6 R7 R8: table walk
        for (int k = 0; k < NV; k++) begin
            step(TBL[k][79:48], TBL[k][47:16], TBL[k][15:8]);
            check_slots($sformatf("R2/R5/R6/R7/R8 vector %0d", k), TBL[k][7:0]);
        end

        // R9: mask change seen with no clock edge (counts 2,3,4,4,4,4,4,0)
        @(negedge clk);
        fetch_ok = 8'h06;
        #1;
        check_slots("R9", {1'b1, 3'd1, 1'b1, 3'd2});

        // R3: push t0 past 63, then compare against t1 held at 62
        do_reset();
        for (int k = 0; k < 16; k++) step(32'h00000004, 32'h0, 8'h03);
        for (int k = 0; k < 15; k++) step(32'h00000040, 32'h0, 8'h03);
        step(32'h00000020, 32'h0, 8'h03);
        check_slots("R3 saturated 63 above 62", {1'b1, 3'd1, 1'b1, 3'd0});
        step(32'h0, 32'h00000002, 8'h03);
        check_slots("R3 63-2=61 below 62", {1'b1, 3'd0, 1'b1, 3'd1});

        // R1: reset clears nonzero counts (before reset t0=61, t1=62 would lose)
        do_reset();
        fetch_ok = 8'hFF;
        #1;
        check_slots("R1 counts cleared", {1'b1, 3'd0, 1'b1, 3'd1});

        // R4: t3 drained below zero while t2 fetches one
        step(32'h00000100, 32'h00002000, 8'h0C);
        check_slots("R4 clamp at zero", {1'b1, 3'd3, 1'b1, 3'd2});
        check_err("R4 flag raised", 1'b1);
        step(32'h0, 32'h0, 8'h0C);
        step(32'h0, 32'h0, 8'h0C);
        check_err("R4 flag sticky", 1'b1);
        do_reset();
        #1;
        check_err("R4 flag cleared by reset", 1'b0);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule